// File: doc/BRIEF.md
# Privilege-Checked Interrupt-Enable Controller

This block sits in the execute stage of a processor core and resolves the system instructions that touch the interrupt-enable (IE) bit or need supervisor rights. Each cycle it can accept one decoded instruction. The instruction arrives as a group selector, a sub-opcode, an immediate and a source operand. The block also takes the current status word, the interrupt control register and an architecture-version code. One cycle later it returns the next interrupt control register value. Where the instruction calls for it, it also returns a register write-back, a trap request with class and identification number, and a pipeline-flush request.

The privilege level comes from two status-word bits. Each instruction has its own rule. The IE set, clear, save and restore instructions are allowed in supervisor or user-1 mode. Special-register writes, the service-routine entry and the monitor return are allowed in supervisor mode only. The system call always traps. The IE bit is at a different position in older and newer architecture layouts, and the save and restore instructions exist only on newer versions.

The consumer applies `icr_o` and the write-back when `done_o` is high. It vectors any trap and restarts fetch on a flush. Trap vectoring, context save and the real effect of special-register writes lie outside this block.

Top module: `ie_priv_ctrl`

## Requirements
- R1: Privilege is read from `psw_i[11:10]`: 0 is user-0, 1 is user-1, 2 is supervisor, and 3 is handled as user-0.
- R2: With group SYS (0), sub-op 0x0c (enable) sets IE and raises `flush_o`, and sub-op 0x0d (disable) clears IE without a flush. Both are allowed in supervisor or user-1 mode.
- R3: Sub-op 0x0f (disable-and-save) writes `{31'b0, old IE}` with `wb_en_o` high and clears IE. Sub-op 0x0e (restore) loads IE from `src_i[0]` and raises `flush_o`.
- R4: In user-0 mode, sub-ops 0x0c, 0x0d, 0x0e and 0x0f raise a protection trap: class 1, identification 1.
- R5: On architecture code 0 (oldest version), sub-ops 0x0e and 0x0f raise an illegal-opcode trap (class 2, identification 1). This check comes before the privilege check.
- R6: IE is bit 8 for architecture codes 0 and 1, and bit 15 for codes 2 and 3. All other bits of `icr_o` equal `icr_i`.
- R7: A special-register write (group 1), the service-routine entry (group 2) and the monitor return (SYS sub-op 0x05) are allowed only in supervisor mode. In any other mode they raise a protection trap (class 1, identification 1). When allowed, they leave ICR unchanged.
- R8: A permitted special-register write to address `imm_i` = 0xfe04 (the status word) raises `flush_o`. A write to any other address does not.
- R9: The system call (group 3) raises a trap of class 6 with identification `imm_i[7:0]` in every mode.
- R10: Whenever a trap is raised, `icr_o` equals the `icr_i` presented with the instruction, and both `wb_en_o` and `flush_o` stay low.
- R11: Any SYS sub-op not listed here raises an illegal-opcode trap (class 2, identification 1).
- R12: Results appear with `done_o` one cycle after `valid_i`. In cycles with no instruction, `done_o`, `trap_o`, `wb_en_o` and `flush_o` are low and `icr_o` follows `icr_i` one cycle later. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| grp_i | input | 2 | Group: 0 SYS, 1 special-register write, 2 service-routine entry, 3 system call |
| op_i | input | 7 | SYS sub-opcode |
| imm_i | input | 16 | Immediate: register address or system-call number |
| src_i | input | 32 | Source register operand |
| psw_i | input | 32 | Current status word |
| icr_i | input | 32 | Current interrupt control register |
| arch_i | input | 2 | Architecture code 0..3, oldest to newest |
| done_o | output | 1 | Result valid |
| icr_o | output | 32 | Next interrupt control register value |
| wb_en_o | output | 1 | Destination register write enable |
| wb_data_o | output | 32 | Destination register value |
| trap_o | output | 1 | Trap request |
| trap_class_o | output | 3 | Trap class |
| trap_tin_o | output | 8 | Trap identification number |
| flush_o | output | 1 | End instruction block, refetch next |

## Verification
The IE instructions are run in every privilege code, including the reserved value 3. A trap in user-0 but not in user-1 shows that permission is decided from the correct status-word field. Each IE instruction is also run on both layouts, with ICR patterns that are all ones and all zeros and with the opposite layout's bit set. This separates a wrong IE position from corruption of neighbouring bits. Running save and restore on the oldest version in user-0 mode shows that the illegal-opcode check takes precedence over the privilege check. Special-register writes to the status-word address and to another address show whether the flush depends on the target.

// File: rtl/ie_priv_pkg.sv
package ie_priv_pkg;

  typedef enum logic [1:0] {
    GRP_SYS   = 2'd0,
    GRP_CSRW  = 2'd1,
    GRP_BISR  = 2'd2,
    GRP_SCALL = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    PRIV_U0 = 2'd0,
    PRIV_U1 = 2'd1,
    PRIV_SV = 2'd2,
    PRIV_RS = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ARCH_V13  = 2'd0,
    ARCH_V16  = 2'd1,
    ARCH_V161 = 2'd2,
    ARCH_V162 = 2'd3
  } arch_e;

  localparam int unsigned OP_W  = 7;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned CLS_W = 3;
  localparam int unsigned TIN_W = 8;

  localparam logic [OP_W-1:0] SYS_RFM     = 7'h05;
  localparam logic [OP_W-1:0] SYS_ENABLE  = 7'h0c;
  localparam logic [OP_W-1:0] SYS_DISABLE = 7'h0d;
  localparam logic [OP_W-1:0] SYS_RESTORE = 7'h0e;
  localparam logic [OP_W-1:0] SYS_DIS_SAV = 7'h0f;

  localparam logic [CLS_W-1:0] TC_PROT  = 3'd1;
  localparam logic [CLS_W-1:0] TC_ILLEG = 3'd2;
  localparam logic [CLS_W-1:0] TC_SCALL = 3'd6;
  localparam logic [TIN_W-1:0] TIN_PRIV = 8'd1;
  localparam logic [TIN_W-1:0] TIN_IOPC = 8'd1;

  typedef struct packed {
    logic              trap;
    logic [CLS_W-1:0]  cls;
    logic [TIN_W-1:0]  tin;
    logic              wb_en;
    logic              ie_we;
    logic              ie_val;
    logic              flush;
  } exec_res_t;

endpackage

// File: rtl/ie_priv_decode.sv
module ie_priv_decode
  import ie_priv_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRIV_LSB = 10
) (
  input  logic [DATA_W-1:0] psw_i,
  output logic              sv_o,
  output logic              sv_u1_o
);
  localparam int unsigned PRIV_MSB = PRIV_LSB + 1;

  priv_e priv;

  always_comb begin
    priv    = priv_e'(psw_i[PRIV_MSB:PRIV_LSB]);
    sv_o    = (priv == PRIV_SV);
    // reserved code falls back to least privileged
    sv_u1_o = (priv == PRIV_SV) || (priv == PRIV_U1);
  end
endmodule

// File: rtl/ie_field.sv
module ie_field
  import ie_priv_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned OLD_POS = 8,
  parameter int unsigned NEW_POS = 15
) (
  input  logic [1:0]        arch_i,
  input  logic [DATA_W-1:0] icr_i,
  input  logic              we_i,
  input  logic              val_i,
  output logic              ie_o,
  output logic [DATA_W-1:0] icr_nxt_o
);
  localparam logic [DATA_W-1:0] OLD_MASK = DATA_W'(1) << OLD_POS;
  localparam logic [DATA_W-1:0] NEW_MASK = DATA_W'(1) << NEW_POS;

  logic              new_layout;
  logic [DATA_W-1:0] mask;

  always_comb begin
    new_layout = (arch_e'(arch_i) == ARCH_V161) || (arch_e'(arch_i) == ARCH_V162);
    mask       = new_layout ? NEW_MASK : OLD_MASK;
    ie_o       = |(icr_i & mask);
    icr_nxt_o  = icr_i;
    if (we_i) begin
      icr_nxt_o = val_i ? (icr_i | mask) : (icr_i & ~mask);
    end
  end
endmodule

// File: rtl/ie_cmd_exec.sv
module ie_cmd_exec
  import ie_priv_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter logic [IMM_W-1:0] PSW_ADDR = 16'hfe04
) (
  input  logic [1:0]        grp_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        arch_i,
  input  logic              sv_i,
  input  logic              sv_u1_i,
  output exec_res_t         res_o
);
  logic has_save;

  always_comb begin
    has_save = (arch_e'(arch_i) != ARCH_V13);
    res_o    = '0;
    unique case (grp_e'(grp_i))
      GRP_SYS: begin
        unique case (op_i)
          SYS_ENABLE: begin
            if (sv_u1_i) begin
              res_o.ie_we  = 1'b1;
              res_o.ie_val = 1'b1;
              res_o.flush  = 1'b1;
            end else begin
              res_o.trap = 1'b1; res_o.cls = TC_PROT; res_o.tin = TIN_PRIV;
            end
          end
          SYS_DISABLE: begin
            if (sv_u1_i) begin
              res_o.ie_we = 1'b1;
            end else begin
              res_o.trap = 1'b1; res_o.cls = TC_PROT; res_o.tin = TIN_PRIV;
            end
          end
          SYS_DIS_SAV: begin
            if (!has_save) begin
              res_o.trap = 1'b1; res_o.cls = TC_ILLEG; res_o.tin = TIN_IOPC;
            end else if (sv_u1_i) begin
              res_o.wb_en = 1'b1;
              res_o.ie_we = 1'b1;
            end else begin
              res_o.trap = 1'b1; res_o.cls = TC_PROT; res_o.tin = TIN_PRIV;
            end
          end
          SYS_RESTORE: begin
            if (!has_save) begin
              res_o.trap = 1'b1; res_o.cls = TC_ILLEG; res_o.tin = TIN_IOPC;
            end else if (sv_u1_i) begin
              res_o.ie_we  = 1'b1;
              res_o.ie_val = src_i[0];
              res_o.flush  = 1'b1;
            end else begin
              res_o.trap = 1'b1; res_o.cls = TC_PROT; res_o.tin = TIN_PRIV;
            end
          end
          SYS_RFM: begin
            if (!sv_i) begin
              res_o.trap = 1'b1; res_o.cls = TC_PROT; res_o.tin = TIN_PRIV;
            end
          end
          default: begin
            res_o.trap = 1'b1; res_o.cls = TC_ILLEG; res_o.tin = TIN_IOPC;
          end
        endcase
      end
      GRP_CSRW: begin
        if (sv_i) begin
          res_o.flush = (imm_i == PSW_ADDR);
        end else begin
          res_o.trap = 1'b1; res_o.cls = TC_PROT; res_o.tin = TIN_PRIV;
        end
      end
      GRP_BISR: begin
        if (!sv_i) begin
          res_o.trap = 1'b1; res_o.cls = TC_PROT; res_o.tin = TIN_PRIV;
        end
      end
      GRP_SCALL: begin
        res_o.trap = 1'b1;
        res_o.cls  = TC_SCALL;
        res_o.tin  = imm_i[TIN_W-1:0];
      end
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/ie_priv_ctrl.sv
module ie_priv_ctrl
  import ie_priv_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRIV_LSB = 10,
  parameter int unsigned OLD_POS  = 8,
  parameter int unsigned NEW_POS  = 15,
  parameter logic [15:0] PSW_ADDR = 16'hfe04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        grp_i,
  input  logic [6:0]        op_i,
  input  logic [15:0]       imm_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] psw_i,
  input  logic [DATA_W-1:0] icr_i,
  input  logic [1:0]        arch_i,
  output logic              done_o,
  output logic [DATA_W-1:0] icr_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              trap_o,
  output logic [2:0]        trap_class_o,
  output logic [7:0]        trap_tin_o,
  output logic              flush_o
);
  logic              sv, sv_u1, ie_cur;
  exec_res_t         res;
  logic [DATA_W-1:0] icr_nxt;

  ie_priv_decode #(.DATA_W(DATA_W), .PRIV_LSB(PRIV_LSB)) priv_i (
    .psw_i   (psw_i),
    .sv_o    (sv),
    .sv_u1_o (sv_u1)
  );

  ie_cmd_exec #(.DATA_W(DATA_W), .PSW_ADDR(PSW_ADDR)) exec_i (
    .grp_i   (grp_i),
    .op_i    (op_i),
    .imm_i   (imm_i),
    .src_i   (src_i),
    .arch_i  (arch_i),
    .sv_i    (sv),
    .sv_u1_i (sv_u1),
    .res_o   (res)
  );

  ie_field #(.DATA_W(DATA_W), .OLD_POS(OLD_POS), .NEW_POS(NEW_POS)) field_i (
    .arch_i    (arch_i),
    .icr_i     (icr_i),
    .we_i      (valid_i & res.ie_we),
    .val_i     (res.ie_val),
    .ie_o      (ie_cur),
    .icr_nxt_o (icr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      icr_o        <= '0;
      wb_en_o      <= 1'b0;
      wb_data_o    <= '0;
      trap_o       <= 1'b0;
      trap_class_o <= '0;
      trap_tin_o   <= '0;
      flush_o      <= 1'b0;
    end else begin
      done_o       <= valid_i;
      icr_o        <= icr_nxt;
      wb_en_o      <= valid_i & res.wb_en;
      wb_data_o    <= {{(DATA_W-1){1'b0}}, ie_cur};
      trap_o       <= valid_i & res.trap;
      trap_class_o <= valid_i ? res.cls : '0;
      trap_tin_o   <= valid_i ? res.tin : '0;
      flush_o      <= valid_i & res.flush;
    end
  end
endmodule

// File: rtl/ie_priv_ctrl_chk.sv
module ie_priv_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        grp_i,
  input logic [6:0]        op_i,
  input logic [15:0]       imm_i,
  input logic [DATA_W-1:0] psw_i,
  input logic [DATA_W-1:0] icr_i,
  input logic              done_o,
  input logic [DATA_W-1:0] icr_o,
  input logic              wb_en_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic              trap_o,
  input logic [2:0]        trap_class_o,
  input logic [7:0]        trap_tin_o,
  input logic              flush_o
);
  // R10
  trap_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && trap_o |-> (icr_o == $past(icr_i)) && !wb_en_o && !flush_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !trap_o && !wb_en_o && !flush_o);

  // R12
  done_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  // R9
  syscall_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && grp_i == 2'd3 |=> trap_o && trap_class_o == 3'd6 && trap_tin_o == $past(imm_i[7:0]));

  // R6
  one_bit_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones(icr_o ^ $past(icr_i)) <= 1);

  // R4
  user0_ie_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && grp_i == 2'd0 && (op_i == 7'h0c || op_i == 7'h0d) && psw_i[11:10] == 2'd0
    |=> trap_o && trap_class_o == 3'd1 && trap_tin_o == 8'd1);

  // R3
  wb_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_data_o[DATA_W-1:1] == '0);
endmodule

bind ie_priv_ctrl ie_priv_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .grp_i        (grp_i),
  .op_i         (op_i),
  .imm_i        (imm_i),
  .psw_i        (psw_i),
  .icr_i        (icr_i),
  .done_o       (done_o),
  .icr_o        (icr_o),
  .wb_en_o      (wb_en_o),
  .wb_data_o    (wb_data_o),
  .trap_o       (trap_o),
  .trap_class_o (trap_class_o),
  .trap_tin_o   (trap_tin_o),
  .flush_o      (flush_o)
);

// File: tb/ie_priv_ctrl_tb_top.sv
module ie_priv_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  grp_i = '0;
  logic [6:0]  op_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] src_i = '0;
  logic [31:0] psw_i = '0;
  logic [31:0] icr_i = '0;
  logic [1:0]  arch_i = '0;
  logic        done_o, wb_en_o, trap_o, flush_o;
  logic [31:0] icr_o, wb_data_o;
  logic [2:0]  trap_class_o;
  logic [7:0]  trap_tin_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ie_priv_ctrl dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic issue(input logic [1:0] g, input logic [6:0] op, input logic [15:0] imm,
                       input logic [31:0] src, input logic [1:0] priv,
                       input logic [31:0] icr, input logic [1:0] arch);
    @(negedge clk_i);
    valid_i = 1'b1; grp_i = g; op_i = op; imm_i = imm; src_i = src;
    psw_i = {20'h0, priv, 10'h0}; icr_i = icr; arch_i = arch;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic expect_trap(input string req, input logic [31:0] icr,
                             input logic [2:0] cls, input logic [7:0] tin);
    chk({req, " trap"}, {31'b0, trap_o}, 32'd1);
    chk({req, " class"}, {29'b0, trap_class_o}, {29'b0, cls});
    chk({req, " tin"}, {24'b0, trap_tin_o}, {24'b0, tin});
    chk({req, " icr kept (R10)"}, icr_o, icr);
    chk({req, " no wb (R10)"}, {31'b0, wb_en_o}, 32'd0);
    chk({req, " no flush (R10)"}, {31'b0, flush_o}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12 reset done", {31'b0, done_o}, 32'd0);
    chk("R12 reset icr", icr_o, 32'd0);
    chk("R12 reset trap", {31'b0, trap_o}, 32'd0);
  endtask

  task automatic t_enable;
    issue(2'd0, 7'h0c, 16'h0, 32'h0, 2'd2, 32'h0, 2'd2);
    chk("R2 enable new layout icr", icr_o, 32'h0000_8000);
    chk("R2 enable flush", {31'b0, flush_o}, 32'd1);
    chk("R2 enable no trap", {31'b0, trap_o}, 32'd0);
    chk("R12 done", {31'b0, done_o}, 32'd1);
    issue(2'd0, 7'h0c, 16'h0, 32'h0, 2'd1, 32'hFFFF_7EFF, 2'd0);
    chk("R6 enable old layout U1", icr_o, 32'hFFFF_7FFF);
  endtask

  task automatic t_disable;
    issue(2'd0, 7'h0d, 16'h0, 32'h0, 2'd1, 32'hFFFF_FFFF, 2'd1);
    chk("R6 disable v16 bit8", icr_o, 32'hFFFF_FEFF);
    chk("R2 disable no flush", {31'b0, flush_o}, 32'd0);
    issue(2'd0, 7'h0d, 16'h0, 32'h0, 2'd2, 32'hFFFF_FFFF, 2'd3);
    chk("R6 disable new bit15", icr_o, 32'hFFFF_7FFF);
  endtask

  task automatic t_dis_save;
    issue(2'd0, 7'h0f, 16'h0, 32'h0, 2'd2, 32'h0000_8000, 2'd3);
    chk("R3 dsave icr", icr_o, 32'h0);
    chk("R3 dsave wb_en", {31'b0, wb_en_o}, 32'd1);
    chk("R3 dsave data", wb_data_o, 32'd1);
    issue(2'd0, 7'h0f, 16'h0, 32'h0, 2'd1, 32'h0000_0100, 2'd3);
    chk("R6 dsave other bit untouched", icr_o, 32'h0000_0100);
    chk("R3 dsave data zero", wb_data_o, 32'd0);
  endtask

  task automatic t_restore;
    issue(2'd0, 7'h0e, 16'h0, 32'h1, 2'd1, 32'h0, 2'd2);
    chk("R3 restore set", icr_o, 32'h0000_8000);
    chk("R3 restore flush", {31'b0, flush_o}, 32'd1);
    issue(2'd0, 7'h0e, 16'h0, 32'hFFFF_FFFE, 2'd2, 32'hFFFF_FFFF, 2'd1);
    chk("R3 restore clear old layout", icr_o, 32'hFFFF_FEFF);
  endtask

  task automatic t_user0;
    issue(2'd0, 7'h0c, 16'h0, 32'h0, 2'd0, 32'h1234_0000, 2'd2);
    expect_trap("R4 enable U0", 32'h1234_0000, 3'd1, 8'd1);
    issue(2'd0, 7'h0d, 16'h0, 32'h0, 2'd3, 32'hFFFF_FFFF, 2'd2);
    expect_trap("R1 reserved priv", 32'hFFFF_FFFF, 3'd1, 8'd1);
    issue(2'd0, 7'h0e, 16'h0, 32'h1, 2'd0, 32'h0, 2'd3);
    expect_trap("R4 restore U0", 32'h0, 3'd1, 8'd1);
  endtask

  task automatic t_arch;
    issue(2'd0, 7'h0f, 16'h0, 32'h0, 2'd2, 32'h0000_0100, 2'd0);
    expect_trap("R5 dsave v13", 32'h0000_0100, 3'd2, 8'd1);
    issue(2'd0, 7'h0e, 16'h0, 32'h1, 2'd0, 32'h0, 2'd0);
    expect_trap("R5 restore v13 U0 precedence", 32'h0, 3'd2, 8'd1);
  endtask

  task automatic t_super;
    issue(2'd1, 7'h0, 16'hfe04, 32'h0, 2'd2, 32'h55, 2'd2);
    chk("R8 psw write flush", {31'b0, flush_o}, 32'd1);
    chk("R7 csr sv no trap", {31'b0, trap_o}, 32'd0);
    chk("R7 csr icr kept", icr_o, 32'h55);
    issue(2'd1, 7'h0, 16'hfe2c, 32'h0, 2'd2, 32'h55, 2'd2);
    chk("R8 other csr no flush", {31'b0, flush_o}, 32'd0);
    issue(2'd1, 7'h0, 16'hfe04, 32'h0, 2'd1, 32'h55, 2'd2);
    expect_trap("R7 csr U1", 32'h55, 3'd1, 8'd1);
    issue(2'd2, 7'h0, 16'h0, 32'h0, 2'd1, 32'h0, 2'd3);
    expect_trap("R7 bisr U1", 32'h0, 3'd1, 8'd1);
    issue(2'd2, 7'h0, 16'h0, 32'h0, 2'd2, 32'h0, 2'd3);
    chk("R7 bisr sv no trap", {31'b0, trap_o}, 32'd0);
    issue(2'd0, 7'h05, 16'h0, 32'h0, 2'd1, 32'h0, 2'd3);
    expect_trap("R7 rfm U1", 32'h0, 3'd1, 8'd1);
    issue(2'd0, 7'h05, 16'h0, 32'h0, 2'd2, 32'h0, 2'd3);
    chk("R7 rfm sv no trap", {31'b0, trap_o}, 32'd0);
  endtask

  task automatic t_syscall;
    issue(2'd3, 7'h0, 16'h01A5, 32'h0, 2'd0, 32'h77, 2'd1);
    expect_trap("R9 syscall U0", 32'h77, 3'd6, 8'hA5);
    issue(2'd3, 7'h0, 16'h0003, 32'h0, 2'd2, 32'h77, 2'd3);
    expect_trap("R9 syscall SV", 32'h77, 3'd6, 8'h03);
  endtask

  task automatic t_unknown;
    issue(2'd0, 7'h12, 16'h0, 32'h0, 2'd2, 32'h8000, 2'd2);
    expect_trap("R11 unknown sub-op", 32'h8000, 3'd2, 8'd1);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    icr_i = 32'hCAFE_1234;
    @(negedge clk_i);
    chk("R12 idle icr follows", icr_o, 32'hCAFE_1234);
    chk("R12 idle done low", {31'b0, done_o}, 32'd0);
    chk("R12 idle trap low", {31'b0, trap_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_enable();
    t_disable();
    t_dis_save();
    t_restore();
    t_user0();
    t_arch();
    t_super();
    t_syscall();
    t_unknown();
    t_idle();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule